// File: doc/BRIEF.md
# Core Supply Window Monitor

This block watches three supply rails as digitised millivolt samples and reports whether the core rail sits in a band around its programmed setpoint. A 5-bit voltage-identification code chooses the core setpoint from two ranges with different step sizes. The upper range also holds one reserved code that shuts the supply down. Every threshold on the core rail is a percentage of the decoded setpoint. The two auxiliary rails are checked against a fixed fraction of their nominal levels.

The block drives three outputs. A power-good flag combines the core band result with both auxiliary checks. An over-voltage flag trips on a ratio of the setpoint, or on a fixed level while the bias supply is still below its power-on level. An inhibit flag marks the reserved code. Comparisons are taken only when the sample strobe is high, and the results are held between strobes. Reset is synchronous and active high.

Top module: `core_rail_guard`

## Requirements
- R1: A code whose bit 4 is 0 sets the target to 2050 - 50*L mV, where L is bits 3:0. Code 01111 gives 1300 mV and code 00000 gives 2050 mV.
- R2: A code whose bit 4 is 1, with L below 15, sets the target to 3500 - 100*L mV. Code 10000 gives 3500 mV and code 11110 gives 2100 mV.
- R3: Code 11111 drives inhibit high from the clock edge after it is applied. While inhibit is high, powerGood is held high and the band state is cleared. With the bias supply good, overVolt is 0.
- R4: When the core rail is out of band, it enters the band on a strobe with floor(T*92/100) < core < floor(T*108/100).
- R5: When the core rail is in band, it stays in band until a strobe sees core < floor(T*90/100) or core > floor(T*110/100).
- R6: powerGood (outside inhibit) requires the core rail to be in band, auxA > floor(2500*75/100)=1875 and auxB > floor(1500*75/100)=1125.
- R7: With biasOk=1, overVolt is set on a strobe when core > floor(T*115/100), and cleared otherwise.
- R8: With biasOk=0, overVolt is set on a strobe when core > 1260 mV, whatever the code.
- R9: Results change only on the clock edge where sampleValid is high. Between strobes they hold, whatever the sample inputs do.
- R10: While rst is high, all outputs are 0 and the band state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vidCode | input | 5 | Core setpoint code |
| sampleValid | input | 1 | Sample strobe |
| biasOk | input | 1 | Bias supply above its power-on level |
| coreMv | input | 16 | Core rail sample, mV |
| auxAMv | input | 16 | First auxiliary rail sample, mV |
| auxBMv | input | 16 | Second auxiliary rail sample, mV |
| powerGood | output | 1 | All rails acceptable (held high under inhibit) |
| overVolt | output | 1 | Core over-voltage |
| inhibit | output | 1 | Reserved shutdown code present |

## Verification
powerGood and overVolt become valid on the first clock edge after a strobed sample, and inhibit on the first edge after a code change. The bench drives each strobe for exactly one cycle starting at a falling edge. It then checks all three outputs at the next falling edge, half a period after the edge that loads them. For hold checks, the sample inputs are moved over several cycles with no strobe, and the outputs are sampled at falling edges to confirm they have not changed.

// File: rtl/rail_guard_pkg.sv
package rail_guard_pkg;

  typedef struct packed {
    logic capture;   // take a comparison on this edge
    logic porMode;   // bias below power-on level: use fixed over-voltage level
  } guardStrobe_t;

  // floor(mv * pct / 100), all in integer millivolts
  function automatic logic [31:0] pctOf(input logic [31:0] mv, input logic [31:0] pct);
    return (mv * pct) / 32'd100;
  endfunction

endpackage

// File: rtl/rail_target_decode.sv
module rail_target_decode #(
  parameter int MV_W         = 16,
  parameter int LOW_TOP_MV   = 2050,
  parameter int LOW_STEP_MV  = 50,
  parameter int HIGH_TOP_MV  = 3500,
  parameter int HIGH_STEP_MV = 100
) (
  input  logic [4:0]      vidCode,
  output logic [MV_W-1:0] targetMv,
  output logic            inhibitCode
);
  localparam logic [3:0] RESERVED_LOW = 4'hF;

  logic [31:0] lowIdx;
  logic [31:0] targetWide;

  always_comb begin
    lowIdx      = 32'(vidCode[3:0]);
    inhibitCode = vidCode[4] && (vidCode[3:0] == RESERVED_LOW);
    if (!vidCode[4])
      targetWide = 32'(LOW_TOP_MV) - 32'(LOW_STEP_MV) * lowIdx;
    else if (inhibitCode)
      targetWide = 32'd0;
    else
      targetWide = 32'(HIGH_TOP_MV) - 32'(HIGH_STEP_MV) * lowIdx;
    targetMv = MV_W'(targetWide);
  end
endmodule

// File: rtl/rail_guard_ctrl.sv
module rail_guard_ctrl
  import rail_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         sampleValid,
  input  logic         biasOk,
  input  logic         inhibitCode,
  output guardStrobe_t strobes,
  output logic         inhibitQ
);
  always_comb begin
    strobes.capture = sampleValid;
    strobes.porMode = !biasOk;
  end

  always_ff @(posedge clk) begin
    if (rst) inhibitQ <= 1'b0;
    else     inhibitQ <= inhibitCode;
  end

  // R10: inhibit is cleared by reset
  assert_inhibit_reset_R10: assert property (@(posedge clk) rst |=> !inhibitQ);
endmodule

// File: rtl/rail_guard_datapath.sv
module rail_guard_datapath
  import rail_guard_pkg::*;
#(
  parameter int MV_W         = 16,
  parameter int AUX_N        = 2,
  parameter int AUX_A_NOM_MV = 2500,
  parameter int AUX_B_NOM_MV = 1500,
  parameter int AUX_UV_PCT   = 75,
  parameter int WIN_LO_ENTER = 92,
  parameter int WIN_LO_EXIT  = 90,
  parameter int WIN_HI_ENTER = 108,
  parameter int WIN_HI_EXIT  = 110,
  parameter int OV_PCT       = 115,
  parameter int POR_OV_MV    = 1260
) (
  input  logic                       clk,
  input  logic                       rst,
  input  guardStrobe_t               strobes,
  input  logic [MV_W-1:0]            targetMv,
  input  logic                       inhibitCode,
  input  logic [MV_W-1:0]            coreMv,
  input  logic [AUX_N-1:0][MV_W-1:0] auxMv,
  output logic                       pgQ,
  output logic                       ovQ
);
  logic [31:0]      core32, tgt32;
  logic [31:0]      loEnter, loExit, hiEnter, hiExit, ovLimit;
  logic [AUX_N-1:0] auxOk;
  logic             inWinQ, inWinNext, pgNext, ovNext;

  assign core32  = 32'(coreMv);
  assign tgt32   = 32'(targetMv);
  assign loEnter = pctOf(tgt32, 32'(WIN_LO_ENTER));
  assign loExit  = pctOf(tgt32, 32'(WIN_LO_EXIT));
  assign hiEnter = pctOf(tgt32, 32'(WIN_HI_ENTER));
  assign hiExit  = pctOf(tgt32, 32'(WIN_HI_EXIT));
  assign ovLimit = pctOf(tgt32, 32'(OV_PCT));

  for (genvar i = 0; i < AUX_N; i++) begin : g_aux
    localparam int NOM = (i == 0) ? AUX_A_NOM_MV : AUX_B_NOM_MV;
    localparam logic [31:0] UV_MV = (32'(NOM) * 32'(AUX_UV_PCT)) / 32'd100;
    assign auxOk[i] = 32'(auxMv[i]) > UV_MV;
  end

  always_comb begin
    if (inhibitCode)
      inWinNext = 1'b0;
    else if (inWinQ)
      inWinNext = (core32 >= loExit) && (core32 <= hiExit);
    else
      inWinNext = (core32 > loEnter) && (core32 < hiEnter);
    pgNext = inWinNext && (&auxOk);
    if (strobes.porMode)
      ovNext = core32 > 32'(POR_OV_MV);
    else
      ovNext = !inhibitCode && (core32 > ovLimit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inWinQ <= 1'b0;
      pgQ    <= 1'b0;
      ovQ    <= 1'b0;
    end else if (strobes.capture) begin
      inWinQ <= inWinNext;
      pgQ    <= pgNext;
      ovQ    <= ovNext;
    end
  end

  // R9: no strobe, no change
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> ($stable(pgQ) && $stable(ovQ)));
  // R6: a failing auxiliary rail blocks power-good
  assert_aux_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && !(&auxOk)) |=> !pgQ);
  // R8: below the fixed level no over-voltage in power-on mode
  assert_por_level_R8: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && strobes.porMode && core32 <= 32'(POR_OV_MV)) |=> !ovQ);
  // R3: reserved code clears the band state
  assert_inhibit_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && inhibitCode) |=> (!inWinQ && !pgQ));
endmodule

// File: rtl/core_rail_guard.sv
module core_rail_guard
  import rail_guard_pkg::*;
#(
  parameter int MV_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      vidCode,
  input  logic            sampleValid,
  input  logic            biasOk,
  input  logic [MV_W-1:0] coreMv,
  input  logic [MV_W-1:0] auxAMv,
  input  logic [MV_W-1:0] auxBMv,
  output logic            powerGood,
  output logic            overVolt,
  output logic            inhibit
);
  guardStrobe_t    strobes;
  logic [MV_W-1:0] targetMv;
  logic            inhibitCode, inhibitQ, pgQ, ovQ;

  rail_target_decode #(.MV_W(MV_W)) u_decode (
    .vidCode(vidCode), .targetMv(targetMv), .inhibitCode(inhibitCode)
  );

  rail_guard_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .biasOk(biasOk),
    .inhibitCode(inhibitCode), .strobes(strobes), .inhibitQ(inhibitQ)
  );

  rail_guard_datapath #(.MV_W(MV_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .targetMv(targetMv),
    .inhibitCode(inhibitCode), .coreMv(coreMv), .auxMv({auxBMv, auxAMv}),
    .pgQ(pgQ), .ovQ(ovQ)
  );

  assign powerGood = pgQ | inhibitQ;
  assign overVolt  = ovQ;
  assign inhibit   = inhibitQ;

  // R3: open power-good while inhibited
  assert_inhibit_pg_R3: assert property (@(posedge clk) disable iff (rst)
    inhibit |-> powerGood);
  // R10: reset clears every output
  assert_reset_out_R10: assert property (@(posedge clk)
    rst |=> (!powerGood && !overVolt && !inhibit));
endmodule

// File: tb/sim_core_rail_guard.sv
module sim_core_rail_guard;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 50000;

  logic clk = 1'b0, rst = 1'b1, sampleValid = 1'b0, biasOk = 1'b1;
  logic [4:0] vidCode = 5'b01111;
  logic [15:0] coreMv = 16'd0, auxAMv = 16'd0, auxBMv = 16'd0;
  logic powerGood, overVolt, inhibit;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  bit mInWin = 1'b0, mPg = 1'b0, mOv = 1'b0, mInh = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_rail_guard u0 (
    .clk(clk), .rst(rst), .vidCode(vidCode), .sampleValid(sampleValid),
    .biasOk(biasOk), .coreMv(coreMv), .auxAMv(auxAMv), .auxBMv(auxBMv),
    .powerGood(powerGood), .overVolt(overVolt), .inhibit(inhibit)
  );

  function automatic int tgtOf(input logic [4:0] c);
    if (!c[4]) return 2050 - 50 * int'(c[3:0]);
    if (c[3:0] == 4'hF) return 0;
    return 3500 - 100 * int'(c[3:0]);
  endfunction

  function automatic int pctB(input int mv, input int p);
    return (mv * p) / 100;
  endfunction

  task automatic modelStep(input logic [4:0] c, input int core, input int a,
                           input int b, input bit bias);
    int t;
    bit inh;
    t = tgtOf(c);
    inh = (c == 5'b11111);
    mInh = inh;
    if (inh) mInWin = 1'b0;
    else if (mInWin) mInWin = (core >= pctB(t, 90)) && (core <= pctB(t, 110));
    else mInWin = (core > pctB(t, 92)) && (core < pctB(t, 108));
    mPg = mInWin && (a > 1875) && (b > 1125);
    if (!bias) mOv = core > 1260;
    else mOv = !inh && (core > pctB(t, 115));
  endtask

  task automatic checkAll(input string req);
    bit ePg;
    ePg = mPg | mInh;
    nChecks++;
    if (powerGood !== ePg || overVolt !== mOv || inhibit !== mInh) begin
      nFails++;
      $display("FAIL %s: pg/ov/inh actual %b%b%b expected %b%b%b code=%b core=%0d",
               req, powerGood, overVolt, inhibit, ePg, mOv, mInh, vidCode, coreMv);
    end
  endtask

  task automatic doSample(input logic [4:0] c, input int core, input int a,
                          input int b, input bit bias, input string req);
    @(negedge clk);
    vidCode = c; coreMv = 16'(core); auxAMv = 16'(a); auxBMv = 16'(b);
    biasOk = bias; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    modelStep(c, core, a, b, bias);
    checkAll(req);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    // R10: outputs low under reset even with a strobe and reserved code
    vidCode = 5'b11111; coreMv = 16'd3000; auxAMv = 16'd2500; auxBMv = 16'd1500;
    sampleValid = 1'b1;
    repeat (3) @(negedge clk);
    checkAll("R10 reset");
    @(negedge clk); rst = 1'b0; sampleValid = 1'b0; vidCode = 5'b01111;
    @(negedge clk);

    // R1 / R7 low range over-voltage edges
    doSample(5'b01111, 1495, 2500, 1500, 1, "R1 R7 code01111 at limit");
    doSample(5'b01111, 1496, 2500, 1500, 1, "R1 R7 code01111 over");
    doSample(5'b00000, 2357, 2500, 1500, 1, "R1 R7 code00000 at limit");
    doSample(5'b00000, 2358, 2500, 1500, 1, "R1 R7 code00000 over");
    // R2 / R7 high range
    doSample(5'b10000, 4025, 2500, 1500, 1, "R2 R7 code10000 at limit");
    doSample(5'b10000, 4026, 2500, 1500, 1, "R2 R7 code10000 over");
    doSample(5'b11110, 2415, 2500, 1500, 1, "R2 R7 code11110 at limit");
    doSample(5'b11110, 2416, 2500, 1500, 1, "R2 R7 code11110 over");
    // R4 / R5 band with hysteresis, T=2100
    doSample(5'b11110, 1932, 2500, 1500, 1, "R4 lower entry edge");
    doSample(5'b11110, 1933, 2500, 1500, 1, "R4 enter");
    doSample(5'b11110, 1890, 2500, 1500, 1, "R5 stay at lower exit");
    doSample(5'b11110, 1889, 2500, 1500, 1, "R5 leave low");
    doSample(5'b11110, 1900, 2500, 1500, 1, "R4 no reentry");
    doSample(5'b11110, 2000, 2500, 1500, 1, "R4 reenter");
    doSample(5'b11110, 2310, 2500, 1500, 1, "R5 stay at upper exit");
    doSample(5'b11110, 2311, 2500, 1500, 1, "R5 leave high");
    doSample(5'b11110, 2268, 2500, 1500, 1, "R4 upper entry edge");
    doSample(5'b11110, 2267, 2500, 1500, 1, "R4 enter from above");
    // R6 auxiliary levels
    doSample(5'b11110, 2100, 1875, 1500, 1, "R6 auxA at level");
    doSample(5'b11110, 2100, 1876, 1125, 1, "R6 auxB at level");
    doSample(5'b11110, 2100, 1876, 1126, 1, "R6 both above");
    // R3 reserved code
    doSample(5'b11111, 5000, 0, 0, 1, "R3 inhibit");
    doSample(5'b11110, 2100, 2500, 1500, 1, "R3 band cleared by inhibit");
    // R8 power-on mode
    doSample(5'b10000, 1261, 2500, 1500, 0, "R8 over fixed level");
    doSample(5'b10000, 1260, 2500, 1500, 0, "R8 at fixed level");
    doSample(5'b11111, 1261, 2500, 1500, 0, "R8 with inhibit");
    // R9 hold without strobe
    doSample(5'b01111, 1700, 2500, 1500, 1, "R9 set ov");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      coreMv = 16'(1300 + k); auxAMv = 16'd0; biasOk = k[0];
      @(negedge clk);
      checkAll("R9 hold");
    end
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [4:0] c;
      int t, core, a, b;
      bit bias;
      c = 5'($urandom % 32);
      t = tgtOf(c);
      if (t == 0) t = 2000;
      core = (t * (85 + int'($urandom % 36))) / 100 + int'($urandom % 5) - 2;
      a = 1800 + int'($urandom % 200);
      b = 1080 + int'($urandom % 100);
      bias = ($urandom % 8) != 0;
      doSample(c, core, a, b, bias, "R4 R5 R6 R7 random");
    end
    // R10 mid-run reset
    doSample(5'b11110, 2100, 2500, 1500, 1, "R10 before reset");
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    mInWin = 1'b0; mPg = 1'b0; mOv = 1'b0; mInh = 1'b0;
    checkAll("R10 mid reset");
    rst = 1'b0;
    doSample(5'b11110, 1900, 2500, 1500, 1, "R10 band cleared");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule